// File: doc/BRIEF.md
# Multithread Fetch-to-Decode Queue Arbiter

This block sits between the fetch stage and the decode stage of a multithreaded core. Every hardware thread owns a small instruction FIFO that fetch fills through a per-thread push port, taking up to a fixed number of instructions per cycle. Each cycle the block gathers up to a decode-width number of instructions from these FIFOs and presents them on a row of decode slots, each slot carrying a valid bit, the thread number and the instruction word.

Fairness between threads comes from a pseudo-random starting point. An 8-bit linear feedback shift register advances every cycle. Its value, taken modulo the number of active threads, picks the thread where the visit begins. The visit then runs through the thread numbers in increasing order, wrapping past the last thread. Each visited thread gives as many instructions as it can before the next thread is considered. A thread that is inactive, stalled by decode, being flushed this cycle, or empty gives nothing. Fetch sees a per-thread fill level so that it can avoid pushing more than a queue can take.

The slot outputs are combinational from the current queue contents and control inputs. Decode takes every valid slot in the cycle it is shown, and the matching entries leave their queues at the next clock edge.

Top module: `fq_decode_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every queue is emptied. After reset every `queue_level` field reads 0 and no `slot_valid` bit is set.
- R2: `push_count` for thread t (bits [t*PW +: PW]) offers 0 to FETCH_W entries, taken from lanes 0 upward of `push_data`, where lane i of thread t is bits [(t*FETCH_W+i)*PAYLOAD_W +: PAYLOAD_W]. The number accepted is the smaller of the offer and the free space, where free space is QUEUE_DEPTH minus the level seen before this cycle's pops. Offered entries beyond that are discarded, so a level never exceeds QUEUE_DEPTH.
- R3: Entries of one thread leave in the order they were pushed. Slot j of the output is bits [j*PAYLOAD_W +: PAYLOAD_W] of `slot_data` and bits [j*TID_W +: TID_W] of `slot_tid`, and slots are filled from slot 0 upward with no gap.
- R4: No more than DECODE_W slots are valid in a cycle. Transfer stops once DECODE_W slots are filled or no eligible thread has entries left. Every unused slot shows `slot_valid` 0.
- R5: A thread whose `decode_stall` bit is 1 places nothing in the slots that cycle, and its level is not reduced by pops.
- R6: The start value is an 8-bit register s. While reset is applied, s is loaded from `lfsr_seed`, and a zero seed is replaced by 1. After reset, s becomes {s[6:0], s[7]^s[5]^s[4]^s[3]} at every clock edge. Let n be the number of active threads. The visit starts at the active thread whose rank, counting active threads upward from thread 0, equals s mod n. Threads are then visited in increasing number, wrapping from the last thread to thread 0.
- R7: Each visited eligible thread gives min(its level, slots still free) entries before the next thread is visited.
- R8: A thread whose `thread_flush` bit is 1 places nothing in the slots that cycle. Its queue is empty after the clock edge, and pushes offered to it in that cycle are discarded.
- R9: A thread whose `thread_active` bit is 0 places nothing in the slots and does not count toward n. If no thread is active, no slot is valid.
- R10: After each clock edge, `queue_level` for thread t (bits [t*LVL_W +: LVL_W]) equals the previous level, minus the entries popped, plus the entries accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lfsr_seed | input | LFSR_W | Start-register value loaded while reset is applied |
| thread_active | input | THREADS | Per-thread active mask |
| decode_stall | input | THREADS | Per-thread decode stall |
| thread_flush | input | THREADS | Per-thread queue flush |
| push_count | input | THREADS*PW | Per-thread number of entries offered |
| push_data | input | THREADS*FETCH_W*PAYLOAD_W | Per-thread, per-lane instruction words |
| queue_level | output | THREADS*LVL_W | Per-thread number of stored entries |
| slot_valid | output | DECODE_W | Valid bit for each decode slot |
| slot_tid | output | DECODE_W*TID_W | Thread number for each slot |
| slot_data | output | DECODE_W*PAYLOAD_W | Instruction word for each slot |

## Verification
Every cycle, the assertions check the following:
- no queue level exceeds the depth;
- a flush leaves its queue empty;
- a pop never exceeds the stored count;
- a full queue that is not drained stays full;
- valid slots are packed from slot 0;
- no valid slot names a stalled, flushed or inactive thread;
- the start register never holds zero.

Only the bench scenarios can show the rest:
- per-thread FIFO order;
- which thread the visit starts at for a given start-register value;
- that each thread is drained greedily before the next;
- which pushes are dropped on a full queue.

The bench reaches these through directed stall, flush and activity sequences and a long mixed run checked against a model.

// File: rtl/fq_pkg.sv
package fq_pkg;

    // Smaller of two counts.
    function automatic int unsigned fq_min(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    // Circular index advance within a buffer of the given size.
    function automatic int unsigned fq_wrap(input int unsigned base, input int unsigned step,
                                            input int unsigned modulus);
        return (base + step) % modulus;
    endfunction

endpackage

// File: rtl/fq_lfsr.sv
module fq_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    // Next-state: shift toward the MSB, feedback enters at bit 0.
    always_comb begin
        state_d = {state_q[W-2:0], ^(state_q & TAPS)};
    end

    // State register; a zero seed would lock the register, so it becomes 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= (seed == '0) ? W'(1) : seed;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R6: the start register never reaches the all-zero lock-up value.
    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/fq_thread_queue.sv
module fq_thread_queue
    import fq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int FETCH_W   = 2,
    parameter int DECODE_W  = 2,
    parameter int PAYLOAD_W = 16,
    localparam int LVL_W    = $clog2(DEPTH + 1),
    localparam int PW       = $clog2(FETCH_W + 1),
    localparam int OW       = $clog2(DECODE_W + 1),
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [PW-1:0]                 push_n,
    input  logic [FETCH_W*PAYLOAD_W-1:0]  push_data,
    input  logic [OW-1:0]                 pop_n,
    output logic [LVL_W-1:0]              level,
    output logic [DECODE_W*PAYLOAD_W-1:0] heads
);

    logic [PAYLOAD_W-1:0] mem [DEPTH];
    logic [AW-1:0]        rd_q;
    logic [AW-1:0]        wr_q;
    logic [LVL_W-1:0]     cnt_q;
    int unsigned          accept_n;

    // Free space is judged on the level before this cycle's pops.
    always_comb begin
        accept_n = fq_min(32'(push_n), DEPTH - 32'(cnt_q));
    end

    // The first DECODE_W entries from the head; only `level` of them are meaningful.
    always_comb begin
        for (int unsigned j = 0; j < DECODE_W; j++) begin
            heads[j*PAYLOAD_W +: PAYLOAD_W] = mem[AW'(fq_wrap(32'(rd_q), j, DEPTH))];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            for (int unsigned i = 0; i < FETCH_W; i++) begin
                if (i < accept_n) begin
                    mem[AW'(fq_wrap(32'(wr_q), i, DEPTH))] <= push_data[i*PAYLOAD_W +: PAYLOAD_W];
                end
            end
            rd_q  <= AW'(fq_wrap(32'(rd_q), 32'(pop_n), DEPTH));
            wr_q  <= AW'(fq_wrap(32'(wr_q), accept_n, DEPTH));
            cnt_q <= LVL_W'(32'(cnt_q) - 32'(pop_n) + accept_n);
        end
    end

    assign level = cnt_q;

    // R10: the level never passes the configured depth.
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= DEPTH);

    // R8: a flush leaves the queue empty at the next edge.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));

    // R4: the selector never pops more than is stored.
    a_r4_pop_within_level: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pop_n) <= 32'(cnt_q));

    // R2: a full queue that is neither drained nor flushed stays full.
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt_q) == DEPTH && pop_n == '0 && !flush) |=> (32'(cnt_q) == DEPTH));

endmodule

// File: rtl/fq_slot_select.sv
module fq_slot_select
    import fq_pkg::*;
#(
    parameter int THREADS   = 4,
    parameter int DEPTH     = 4,
    parameter int DECODE_W  = 2,
    parameter int PAYLOAD_W = 16,
    parameter int LFSR_W    = 8,
    localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int LVL_W    = $clog2(DEPTH + 1),
    localparam int OW       = $clog2(DECODE_W + 1)
) (
    input  logic [LFSR_W-1:0]                     rand_val,
    input  logic [THREADS-1:0]                    active,
    input  logic [THREADS-1:0]                    stall,
    input  logic [THREADS-1:0]                    flush,
    input  logic [THREADS*LVL_W-1:0]              levels,
    input  logic [THREADS*DECODE_W*PAYLOAD_W-1:0] heads,
    output logic [THREADS*OW-1:0]                 pops,
    output logic [DECODE_W-1:0]                   slot_valid,
    output logic [DECODE_W*TID_W-1:0]             slot_tid,
    output logic [DECODE_W*PAYLOAD_W-1:0]         slot_data
);

    always_comb begin
        int unsigned n_act;
        int unsigned rank;
        int unsigned seen;
        int unsigned start;
        int unsigned used;
        int unsigned t;
        int unsigned take;

        n_act = $countones(active);
        rank  = 0;
        seen  = 0;
        start = 0;
        used  = 0;
        t     = 0;
        take  = 0;
        if (n_act != 0) begin
            rank = 32'(rand_val) % n_act;
        end

        // Locate the active thread holding the chosen rank.
        for (int unsigned i = 0; i < THREADS; i++) begin
            if (active[i]) begin
                if (seen == rank) begin
                    start = i;
                end
                seen = seen + 1;
            end
        end

        pops       = '0;
        slot_valid = '0;
        slot_tid   = '0;
        slot_data  = '0;

        // Rotating greedy fill: drain each eligible thread before the next.
        for (int unsigned k = 0; k < THREADS; k++) begin
            t    = (start + k) % THREADS;
            take = 0;
            if (active[t] && !stall[t] && !flush[t]) begin
                take = fq_min(32'(levels[t*LVL_W +: LVL_W]), DECODE_W - used);
            end
            pops[t*OW +: OW] = OW'(take);
            for (int unsigned j = 0; j < DECODE_W; j++) begin
                if (j < take) begin
                    slot_valid[used + j]                        = 1'b1;
                    slot_tid[(used + j)*TID_W +: TID_W]         = TID_W'(t);
                    slot_data[(used + j)*PAYLOAD_W +: PAYLOAD_W] =
                        heads[(t*DECODE_W + j)*PAYLOAD_W +: PAYLOAD_W];
                end
            end
            used = used + take;
        end
    end

endmodule

// File: rtl/fq_decode_arbiter.sv
module fq_decode_arbiter #(
    parameter int              THREADS   = 4,
    parameter int              DEPTH     = 4,
    parameter int              FETCH_W   = 2,
    parameter int              DECODE_W  = 2,
    parameter int              PAYLOAD_W = 16,
    parameter int              LFSR_W    = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PW    = $clog2(FETCH_W + 1),
    localparam int OW    = $clog2(DECODE_W + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [LFSR_W-1:0]                    lfsr_seed,
    input  logic [THREADS-1:0]                   thread_active,
    input  logic [THREADS-1:0]                   decode_stall,
    input  logic [THREADS-1:0]                   thread_flush,
    input  logic [THREADS*PW-1:0]                push_count,
    input  logic [THREADS*FETCH_W*PAYLOAD_W-1:0] push_data,
    output logic [THREADS*LVL_W-1:0]             queue_level,
    output logic [DECODE_W-1:0]                  slot_valid,
    output logic [DECODE_W*TID_W-1:0]            slot_tid,
    output logic [DECODE_W*PAYLOAD_W-1:0]        slot_data
);

    logic [LFSR_W-1:0]                     rand_val;
    logic [THREADS*OW-1:0]                 pops;
    logic [THREADS*DECODE_W*PAYLOAD_W-1:0] heads;

    fq_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS)
    ) u_start_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (lfsr_seed),
        .state (rand_val)
    );

    for (genvar g = 0; g < THREADS; g++) begin : g_queue
        fq_thread_queue #(
            .DEPTH     (DEPTH),
            .FETCH_W   (FETCH_W),
            .DECODE_W  (DECODE_W),
            .PAYLOAD_W (PAYLOAD_W)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (thread_flush[g]),
            .push_n    (push_count[g*PW +: PW]),
            .push_data (push_data[g*FETCH_W*PAYLOAD_W +: FETCH_W*PAYLOAD_W]),
            .pop_n     (pops[g*OW +: OW]),
            .level     (queue_level[g*LVL_W +: LVL_W]),
            .heads     (heads[g*DECODE_W*PAYLOAD_W +: DECODE_W*PAYLOAD_W])
        );
    end

    fq_slot_select #(
        .THREADS   (THREADS),
        .DEPTH     (DEPTH),
        .DECODE_W  (DECODE_W),
        .PAYLOAD_W (PAYLOAD_W),
        .LFSR_W    (LFSR_W)
    ) u_select (
        .rand_val   (rand_val),
        .active     (thread_active),
        .stall      (decode_stall),
        .flush      (thread_flush),
        .levels     (queue_level),
        .heads      (heads),
        .pops       (pops),
        .slot_valid (slot_valid),
        .slot_tid   (slot_tid),
        .slot_data  (slot_data)
    );

    for (genvar j = 0; j < DECODE_W; j++) begin : g_slot_chk
        if (j > 0) begin : g_packed
            // R3, R4: valid slots form an unbroken run from slot 0.
            a_r4_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[j] |-> slot_valid[j-1]);
        end
        // R5: a stalled thread never occupies a slot.
        a_r5_no_stalled_slot: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[j] |-> !decode_stall[slot_tid[j*TID_W +: TID_W]]);
        // R8: a thread being flushed never occupies a slot.
        a_r8_no_flushed_slot: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[j] |-> !thread_flush[slot_tid[j*TID_W +: TID_W]]);
        // R9: an inactive thread never occupies a slot.
        a_r9_no_inactive_slot: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[j] |-> thread_active[slot_tid[j*TID_W +: TID_W]]);
    end

endmodule

// File: tb/test_fq_decode_arbiter.sv
module test_fq_decode_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int T     = 4;
    localparam int D     = 4;
    localparam int FW    = 2;
    localparam int DW    = 2;
    localparam int P     = 16;
    localparam int LW    = 8;
    localparam int TW    = $clog2(T);
    localparam int CW    = $clog2(D + 1);
    localparam int PW    = $clog2(FW + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [LW-1:0]     lfsr_seed;
    logic [T-1:0]      thread_active;
    logic [T-1:0]      decode_stall;
    logic [T-1:0]      thread_flush;
    logic [T*PW-1:0]   push_count;
    logic [T*FW*P-1:0] push_data;
    logic [T*CW-1:0]   queue_level;
    logic [DW-1:0]     slot_valid;
    logic [DW*TW-1:0]  slot_tid;
    logic [DW*P-1:0]   slot_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    fq_decode_arbiter #(
        .THREADS (T), .DEPTH (D), .FETCH_W (FW), .DECODE_W (DW),
        .PAYLOAD_W (P), .LFSR_W (LW), .LFSR_TAPS (8'hB8)
    ) i_fq_decode_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .lfsr_seed     (lfsr_seed),
        .thread_active (thread_active),
        .decode_stall  (decode_stall),
        .thread_flush  (thread_flush),
        .push_count    (push_count),
        .push_data     (push_data),
        .queue_level   (queue_level),
        .slot_valid    (slot_valid),
        .slot_tid      (slot_tid),
        .slot_data     (slot_data)
    );

    typedef struct {
        int          tid;
        logic [P-1:0] data;
    } item_t;

    logic [P-1:0] mq [T][$];
    item_t        exp_q [$];
    logic [LW-1:0] mlfsr;
    int           n_checks = 0;
    int           n_fail   = 0;
    int           seq      = 0;
    string        cur_req  = "R1";

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] lfsr_next(input logic [LW-1:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic offer(input int t, input int n);
        push_count[t*PW +: PW] = PW'(n);
        for (int i = 0; i < FW; i++) begin
            push_data[(t*FW + i)*P +: P] = P'(t*4096 + (seq % 4096));
            seq++;
        end
    endtask

    task automatic reset_dut(input logic [LW-1:0] seed);
        rst_n         = 1'b0;
        lfsr_seed     = seed;
        thread_active = '1;
        decode_stall  = '0;
        thread_flush  = '0;
        push_count    = '0;
        push_data     = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < T; t++) mq[t].delete();
        exp_q.delete();
        mlfsr = (seed == '0) ? LW'(1) : seed;
    endtask

    // One cycle: the driver part builds expected slot items, the monitor part
    // pops and compares them, then the model advances across the edge.
    task automatic step();
        int          pops [T];
        int          n_act, rank, seen, start, used, take, t, acc, oldsz;
        logic [T-1:0] act, stl, fl;
        logic [T*PW-1:0] pc;
        logic [T*FW*P-1:0] pd;
        #1;
        act = thread_active; stl = decode_stall; fl = thread_flush;
        pc  = push_count;    pd  = push_data;
        for (int q = 0; q < T; q++) begin
            chk(cur_req, $sformatf("level of thread %0d", q),
                int'(queue_level[q*CW +: CW]), mq[q].size());
        end
        n_act = $countones(act); rank = 0; seen = 0; start = 0; used = 0;
        if (n_act != 0) rank = int'(mlfsr) % n_act;
        for (int q = 0; q < T; q++) begin
            if (act[q]) begin
                if (seen == rank) start = q;
                seen++;
            end
        end
        for (int k = 0; k < T; k++) begin
            t = (start + k) % T;
            take = 0;
            if (act[t] && !stl[t] && !fl[t]) take = min2(mq[t].size(), DW - used);
            for (int j = 0; j < take; j++) begin
                item_t e;
                e.tid  = t;
                e.data = mq[t][j];
                exp_q.push_back(e);
            end
            pops[t] = take;
            used += take;
        end
        for (int j = 0; j < DW; j++) begin
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                chk(cur_req, $sformatf("slot %0d valid", j), int'(slot_valid[j]), 1);
                chk(cur_req, $sformatf("slot %0d thread", j), int'(slot_tid[j*TW +: TW]), e.tid);
                chk(cur_req, $sformatf("slot %0d data", j), int'(slot_data[j*P +: P]), int'(e.data));
            end else begin
                chk(cur_req, $sformatf("slot %0d unused valid", j), int'(slot_valid[j]), 0);
            end
        end
        @(posedge clk);
        for (int q = 0; q < T; q++) begin
            oldsz = mq[q].size();
            if (fl[q]) begin
                mq[q].delete();
            end else begin
                for (int j = 0; j < pops[q]; j++) void'(mq[q].pop_front());
                acc = min2(int'(pc[q*PW +: PW]), D - oldsz);
                for (int i = 0; i < acc; i++) mq[q].push_back(pd[(q*FW + i)*P +: P]);
            end
        end
        mlfsr = lfsr_next(mlfsr);
        @(negedge clk);
        push_count = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        reset_dut(8'h5A);

        // R1: reset state.
        cur_req = "R1";
        step();
        step();

        // R2, R10: a stalled thread fills up; excess offers are dropped.
        cur_req = "R2";
        decode_stall = '1;
        for (int c = 0; c < 3; c++) begin offer(0, 2); step(); end
        offer(0, 1); step();
        cur_req = "R10";
        offer(1, 1); step();
        offer(1, 2); step();
        step();

        // R5: stalled threads stay put while another thread fills.
        cur_req = "R5";
        offer(2, 2); step();
        step();
        decode_stall = 4'b1011;
        step();
        step();

        // R3, R6, R7: release the stalls and drain in rotating greedy order.
        cur_req = "R3";
        decode_stall = '0;
        step();
        cur_req = "R7";
        for (int c = 0; c < 3; c++) step();
        cur_req = "R6";
        for (int c = 0; c < 3; c++) step();

        // R8: flush a stalled full queue with a same-cycle offer, then a live one.
        cur_req = "R8";
        decode_stall = 4'b0010;
        offer(1, 2); step();
        offer(1, 2); step();
        thread_flush = 4'b0010;
        offer(1, 2); step();
        thread_flush = '0;
        step();
        decode_stall = '0;
        offer(3, 2); step();
        thread_flush = 4'b1000;
        step();
        thread_flush = '0;
        step();

        // R9: inactive threads keep their entries and are never chosen.
        cur_req = "R9";
        thread_active = 4'b0101;
        for (int q = 0; q < T; q++) offer(q, 2);
        step();
        for (int c = 0; c < 4; c++) step();
        thread_active = '0;
        offer(1, 1);
        step();
        step();
        thread_active = '1;
        for (int c = 0; c < 5; c++) step();

        // R4, R7: mixed traffic against the model.
        cur_req = "R4";
        for (int c = 0; c < 400; c++) begin
            for (int q = 0; q < T; q++) offer(q, $urandom_range(FW));
            for (int q = 0; q < T; q++) begin
                decode_stall[q] = ($urandom_range(3) == 0);
                thread_flush[q] = ($urandom_range(31) == 0);
            end
            thread_active = ($urandom_range(7) == 0) ? T'($urandom_range(15)) : '1;
            step();
        end
        thread_flush = '0;
        decode_stall = '0;
        thread_active = '1;

        // R6, R1: a zero seed restarts from 1.
        reset_dut(8'h00);
        cur_req = "R6";
        step();
        for (int q = 0; q < T; q++) offer(q, 2);
        step();
        for (int c = 0; c < 8; c++) step();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule